// File: doc/BRIEF.md
# FIFO Interrupt and DMA Request Router

This block sits between six command/result FIFO pairs of a converter subsystem and the chip's interrupt controller and DMA engine. For each channel it keeps a small control word and a set of status flags. Three error conditions per channel are held as sticky flags: result overflow, command underflow and trigger overrun. Software clears them by writing ones to the status word. The result-FIFO drain condition follows a not-empty input directly. A select bit steers it either to a per-channel DMA request or to a per-channel interrupt. Each channel also has its own overflow interrupt. One combined error interrupt collects all eighteen error flags, each gated by its own enable.

A DMA drain request is tracked per channel by a two-state machine. In `DRN_IDLE` no request is outstanding. The `ARM` transition enters `DRN_WAIT` when drain enable, drain select and not-empty are all high. In `DRN_WAIT` the request is held. The `DONE` transition returns to `DRN_IDLE` when an acknowledge pulse arrives while the FIFO reads empty. The `ABORT` transition returns to `DRN_IDLE` as soon as drain enable or drain select is low. Clearing either bit while a request is outstanding and unacknowledged is a software error, and the block reports it on a pulse output.

The register bus is a simple single-cycle write port and a combinational read port. Address bit 0 selects the control word (0) or the status word (1), and the upper address bits select the channel. Addresses of channels 6 and 7 are ignored on write and read as zero.

Top module: `fifo_req_router`

## Requirements
- R1: After reset, every control and status word reads 0 and every request output (ovf_irq, drain_irq, dma_req, err_irq, prot_err) is low.
- R2: A control write stores only trigger-overrun enable (bit 0), underflow enable (bit 1), overflow enable (bit 12), drain enable (bit 14) and drain select (bit 15). All other bits, including bits 8 to 11 and 13, read as zero. Writes to channels 6 and 7 are ignored, and those addresses read zero.
- R3: The status word shows the overflow flag at bit 0, underflow at bit 1 and trigger overrun at bit 2. Each flag sets on a one-cycle event pulse and stays set. Writing 1 to a bit of the status word clears only that bit. An event in the same cycle as a clear leaves the flag set.
- R4: ovf_irq[i] is high exactly one clock after channel i has both its overflow flag and its overflow enable set, and it stays low while the enable is clear.
- R5: err_irq is high one clock after any of the 18 flags (overflow, underflow, trigger overrun of six channels) is set together with its own enable bit, and it is low otherwise.
- R6: While drain enable is 0, neither dma_req nor drain_irq of that channel is asserted, whatever the not-empty input.
- R7: Status bit 3 mirrors the channel's result-not-empty input. With drain enable 1 and drain select 0, drain_irq follows not-empty one clock later and dma_req stays low.
- R8: With drain enable 1 and drain select 1, dma_req rises one clock after not-empty is seen high. It stays high through an acknowledge taken while the FIFO is still not empty, and through the FIFO emptying without an acknowledge. It falls one clock after an acknowledge taken while not-empty is low.
- R9: prot_err pulses for one cycle, in the cycle after a control write that clears drain enable or drain select of a channel whose dma_req is high and not acknowledged in that cycle. Control writes that keep both bits set, and writes to other channels, raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: [3:1] channel, [0] 0 = control, 1 = status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address, same layout as wr_addr |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| ovf_evt | input | 6 | Result overflow event pulse per channel |
| unf_evt | input | 6 | Command underflow event pulse per channel |
| tor_evt | input | 6 | Trigger overrun event pulse per channel |
| rf_nempty | input | 6 | Result FIFO not-empty level per channel |
| dma_ack | input | 6 | DMA acknowledge pulse per channel |
| ovf_irq | output | 6 | Per-channel overflow interrupt |
| drain_irq | output | 6 | Per-channel drain interrupt |
| dma_req | output | 6 | Per-channel drain DMA request |
| err_irq | output | 1 | Combined error interrupt |
| prot_err | output | 1 | Drain control cleared during an outstanding DMA request |

## Verification
The bench targets the same-cycle collision of an event pulse and a write-1-to-clear. A design that gave the clear priority would lose an error event and read the flag as 0. It also sends an acknowledge while the FIFO is still not empty, and lets the FIFO empty with no acknowledge. A state machine that completed on either condition alone would drop dma_req early. The bench writes to reserved bits and to the unused channel addresses, where bad decoding would show stray bits on read-back. It also clears drain select under an outstanding request, and writes control words that keep the drain bits set. The first must pulse prot_err and the second must not, so a mis-qualified error output fails in one direction or the other.

// File: rtl/frr_pkg.sv
`timescale 1ns/1ps
package frr_pkg;
    localparam int CTL_W = 16;

    // control word bit positions
    localparam int B_TOR_IE  = 0;
    localparam int B_UNF_IE  = 1;
    localparam int B_OVF_IE  = 12;
    localparam int B_DRN_EN  = 14;
    localparam int B_DRN_SEL = 15;

    // status word bit positions
    localparam int S_OVF = 0;
    localparam int S_UNF = 1;
    localparam int S_TOR = 2;
    localparam int S_DRN = 3;

    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_WAIT = 1'b1
    } drn_state_e;

    typedef struct packed {
        logic drn_sel;
        logic drn_en;
        logic ovf_ie;
        logic unf_ie;
        logic tor_ie;
    } ctl_t;

    typedef struct packed {
        logic tor;
        logic unf;
        logic ovf;
    } flg_t;
endpackage

// File: rtl/frr_drain_fsm.sv
`timescale 1ns/1ps
module frr_drain_fsm
    import frr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drn_en,
    input  logic drn_sel,
    input  logic rf_nempty,
    input  logic dma_ack,
    output logic dma_req
);
    drn_state_e st_q;
    drn_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DRN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DRN_IDLE: begin
                // ARM
                if (drn_en && drn_sel && rf_nempty) st_d = DRN_WAIT;
            end
            DRN_WAIT: begin
                if (!drn_en || !drn_sel)           st_d = DRN_IDLE; // ABORT
                else if (dma_ack && !rf_nempty)    st_d = DRN_IDLE; // DONE
            end
            default: st_d = DRN_IDLE;
        endcase
    end

    always_comb dma_req = (st_q == DRN_WAIT);
endmodule

// File: rtl/frr_chan.sv
`timescale 1ns/1ps
module frr_chan
    import frr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic sts_we,
    input  ctl_t wr_ctl,
    input  flg_t wr_clr,
    input  logic ovf_evt,
    input  logic unf_evt,
    input  logic tor_evt,
    input  logic rf_nempty,
    input  logic dma_ack,
    output ctl_t ctl_q,
    output flg_t flg_q,
    output logic ovf_irq,
    output logic drain_irq,
    output logic dma_req,
    output logic err_term,
    output logic perr
);
    logic ovf_irq_q;
    logic drain_irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            flg_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= wr_ctl;
            flg_q.ovf <= ovf_evt | (flg_q.ovf & ~(sts_we & wr_clr.ovf));
            flg_q.unf <= unf_evt | (flg_q.unf & ~(sts_we & wr_clr.unf));
            flg_q.tor <= tor_evt | (flg_q.tor & ~(sts_we & wr_clr.tor));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_irq_q   <= 1'b0;
            drain_irq_q <= 1'b0;
        end else begin
            ovf_irq_q   <= ctl_q.ovf_ie & flg_q.ovf;
            drain_irq_q <= ctl_q.drn_en & ~ctl_q.drn_sel & rf_nempty;
        end
    end

    frr_drain_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .drn_en    (ctl_q.drn_en),
        .drn_sel   (ctl_q.drn_sel),
        .rf_nempty (rf_nempty),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req)
    );

    always_comb begin
        ovf_irq   = ovf_irq_q;
        drain_irq = drain_irq_q;
        err_term  = (ctl_q.ovf_ie & flg_q.ovf) |
                    (ctl_q.unf_ie & flg_q.unf) |
                    (ctl_q.tor_ie & flg_q.tor);
        perr      = ctl_we & dma_req & ~dma_ack &
                    (~wr_ctl.drn_en | ~wr_ctl.drn_sel);
    end
endmodule

// File: rtl/fifo_req_router.sv
`timescale 1ns/1ps
module fifo_req_router
    import frr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int AW     = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [CTL_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] ovf_evt,
    input  logic [NUM_CH-1:0] unf_evt,
    input  logic [NUM_CH-1:0] tor_evt,
    input  logic [NUM_CH-1:0] rf_nempty,
    input  logic [NUM_CH-1:0] dma_ack,
    output logic [NUM_CH-1:0] ovf_irq,
    output logic [NUM_CH-1:0] drain_irq,
    output logic [NUM_CH-1:0] dma_req,
    output logic              err_irq,
    output logic              prot_err
);
    localparam int CH_AW = AW - 1;

    logic [CH_AW-1:0] wr_ch;
    logic [CH_AW-1:0] rd_ch;
    ctl_t             wr_ctl;
    flg_t             wr_clr;

    logic [NUM_CH-1:0] ctl_oie, ctl_uie, ctl_tie, ctl_den, ctl_dsel;
    logic [NUM_CH-1:0] fl_ovf, fl_unf, fl_tor;
    logic [NUM_CH-1:0] err_term, perr;
    logic [CTL_W-1:0]  ctl_word [NUM_CH];
    logic [CTL_W-1:0]  sts_word [NUM_CH];

    logic err_q;
    logic perr_q;

    always_comb begin
        wr_ch          = wr_addr[AW-1:1];
        rd_ch          = rd_addr[AW-1:1];
        wr_ctl.tor_ie  = wr_data[B_TOR_IE];
        wr_ctl.unf_ie  = wr_data[B_UNF_IE];
        wr_ctl.ovf_ie  = wr_data[B_OVF_IE];
        wr_ctl.drn_en  = wr_data[B_DRN_EN];
        wr_ctl.drn_sel = wr_data[B_DRN_SEL];
        wr_clr.ovf     = wr_data[S_OVF];
        wr_clr.unf     = wr_data[S_UNF];
        wr_clr.tor     = wr_data[S_TOR];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ctl_t ctl_q;
        flg_t flg_q;
        logic ctl_we;
        logic sts_we;

        always_comb begin
            ctl_we = wr_en && !wr_addr[0] && (wr_ch == CH_AW'(i));
            sts_we = wr_en &&  wr_addr[0] && (wr_ch == CH_AW'(i));
        end

        frr_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we),
            .sts_we    (sts_we),
            .wr_ctl    (wr_ctl),
            .wr_clr    (wr_clr),
            .ovf_evt   (ovf_evt[i]),
            .unf_evt   (unf_evt[i]),
            .tor_evt   (tor_evt[i]),
            .rf_nempty (rf_nempty[i]),
            .dma_ack   (dma_ack[i]),
            .ctl_q     (ctl_q),
            .flg_q     (flg_q),
            .ovf_irq   (ovf_irq[i]),
            .drain_irq (drain_irq[i]),
            .dma_req   (dma_req[i]),
            .err_term  (err_term[i]),
            .perr      (perr[i])
        );

        always_comb begin
            ctl_oie[i]  = ctl_q.ovf_ie;
            ctl_uie[i]  = ctl_q.unf_ie;
            ctl_tie[i]  = ctl_q.tor_ie;
            ctl_den[i]  = ctl_q.drn_en;
            ctl_dsel[i] = ctl_q.drn_sel;
            fl_ovf[i]   = flg_q.ovf;
            fl_unf[i]   = flg_q.unf;
            fl_tor[i]   = flg_q.tor;

            ctl_word[i]            = '0;
            ctl_word[i][B_TOR_IE]  = ctl_q.tor_ie;
            ctl_word[i][B_UNF_IE]  = ctl_q.unf_ie;
            ctl_word[i][B_OVF_IE]  = ctl_q.ovf_ie;
            ctl_word[i][B_DRN_EN]  = ctl_q.drn_en;
            ctl_word[i][B_DRN_SEL] = ctl_q.drn_sel;

            sts_word[i]        = '0;
            sts_word[i][S_OVF] = flg_q.ovf;
            sts_word[i][S_UNF] = flg_q.unf;
            sts_word[i][S_TOR] = flg_q.tor;
            sts_word[i][S_DRN] = rf_nempty[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_AW'(i)) rd_data = rd_addr[0] ? sts_word[i] : ctl_word[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            err_q  <= |err_term;
            perr_q <= |perr;
        end
    end

    always_comb begin
        err_irq  = err_q;
        prot_err = perr_q;
    end
endmodule

// File: rtl/frr_chk.sv
`timescale 1ns/1ps
module frr_chk #(
    parameter int NUM_CH = 6,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic              wr_d0,
    input logic [NUM_CH-1:0] ovf_irq,
    input logic [NUM_CH-1:0] drain_irq,
    input logic [NUM_CH-1:0] dma_req,
    input logic [NUM_CH-1:0] dma_ack,
    input logic              err_irq,
    input logic              prot_err,
    input logic [NUM_CH-1:0] ctl_oie,
    input logic [NUM_CH-1:0] ctl_uie,
    input logic [NUM_CH-1:0] ctl_tie,
    input logic [NUM_CH-1:0] ctl_den,
    input logic [NUM_CH-1:0] ctl_dsel,
    input logic [NUM_CH-1:0] fl_ovf
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R6
        drain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_den[i] |=> (!dma_req[i] && !drain_irq[i]));

        // R7
        drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(dma_req[i] && drain_irq[i]));

        // R3
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fl_ovf[i] && !(wr_en && wr_addr == AW'(2*i+1) && wr_d0)) |=> fl_ovf[i]);

        // R8
        dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[i] && !dma_ack[i] && ctl_den[i] && ctl_dsel[i]) |=> dma_req[i]);

        // R4
        ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_oie[i] |=> !ovf_irq[i]);
    end

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oie == '0 && ctl_uie == '0 && ctl_tie == '0) |=> !err_irq);

    // R9
    perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ($past(wr_en) && ($past(dma_req) != '0)));
endmodule

bind fifo_req_router frr_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_d0     (wr_data[0]),
    .ovf_irq   (ovf_irq),
    .drain_irq (drain_irq),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .err_irq   (err_irq),
    .prot_err  (prot_err),
    .ctl_oie   (ctl_oie),
    .ctl_uie   (ctl_uie),
    .ctl_tie   (ctl_tie),
    .ctl_den   (ctl_den),
    .ctl_dsel  (ctl_dsel),
    .fl_ovf    (fl_ovf)
);

// File: tb/fifo_req_router_tb.sv
`timescale 1ns/1ps
module fifo_req_router_tb;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [NCH-1:0] ovf_evt = '0, unf_evt = '0, tor_evt = '0;
    logic [NCH-1:0] rf_nempty = '0, dma_ack = '0;
    logic [NCH-1:0] ovf_irq, drain_irq, dma_req;
    logic        err_irq, prot_err;

    always #2 clk = ~clk;

    fifo_req_router u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .tor_evt(tor_evt),
        .rf_nempty(rf_nempty), .dma_ack(dma_ack), .ovf_irq(ovf_irq),
        .drain_irq(drain_irq), .dma_req(dma_req), .err_irq(err_irq),
        .prot_err(prot_err)
    );

    typedef enum int {O_RD, O_OVF, O_DIRQ, O_DMA, O_ERR, O_PERR} obs_e;
    typedef struct {
        int          due;
        obs_e        what;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(obs_e w);
        case (w)
            O_RD:    return rd_data;
            O_OVF:   return {10'b0, ovf_irq};
            O_DIRQ:  return {10'b0, drain_irq};
            O_DMA:   return {10'b0, dma_req};
            O_ERR:   return {15'b0, err_irq};
            default: return {15'b0, prot_err};
        endcase
    endfunction

    // monitor: pops due items and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int k = sb_q.size() - 1; k >= 0; k--) begin
                if (sb_q[k].due == cyc) begin
                    logic [15:0] act;
                    act = observe(sb_q[k].what);
                    n_vec++;
                    if (act !== sb_q[k].exp) begin
                        n_bad++;
                        $display("FAIL %s (%s): actual %h expected %h at cycle %0d",
                                 sb_q[k].tag, sb_q[k].what.name(), act, sb_q[k].exp, cyc);
                    end
                    sb_q.delete(k);
                end
            end
        end
    end

    task automatic expect_at(input int off, input obs_e w, input logic [15:0] v, input string tag);
        item_t it;
        it.due = cyc + off; it.what = w; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [15:0] v, input string tag);
        rd_addr = a;
        expect_at(0, O_RD, v, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        if (kind == 0) ovf_evt[ch] = 1'b1;
        else if (kind == 1) unf_evt[ch] = 1'b1;
        else tor_evt[ch] = 1'b1;
        @(negedge clk);
        ovf_evt = '0; unf_evt = '0; tor_evt = '0;
    endtask

    task automatic set_ne(input int ch, input logic v);
        @(negedge clk);
        rf_nempty[ch] = v;
        @(negedge clk);
    endtask

    task automatic ack_pulse(input int ch, input logic ne);
        @(negedge clk);
        dma_ack[ch] = 1'b1; rf_nempty[ch] = ne;
        @(negedge clk);
        dma_ack = '0;
    endtask

    // watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk_rd(4'd0, 16'h0000, "R1");
        expect_at(0, O_DMA, 16'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        chk_rd(4'd1, 16'h0000, "R1");
        expect_at(0, O_OVF, 16'h0, "R1");
        expect_at(0, O_DIRQ, 16'h0, "R1");
        expect_at(0, O_ERR, 16'h0, "R1");
        expect_at(0, O_PERR, 16'h0, "R1");

        // R2: control storage, reserved bits, unused channels
        wr(4'd4, 16'hFFFF);
        chk_rd(4'd4, 16'hD003, "R2");
        wr(4'd4, 16'h2F00);
        chk_rd(4'd4, 16'h0000, "R2");
        wr(4'd14, 16'hFFFF);
        chk_rd(4'd14, 16'h0000, "R2");
        wr(4'd12, 16'hFFFF);
        chk_rd(4'd12, 16'h0000, "R2");

        // R3/R4/R5: overflow on channel 1 with enable
        wr(4'd2, 16'h1000);
        pulse(0, 1);
        chk_rd(4'd3, 16'h0001, "R3");
        expect_at(1, O_OVF, 16'h0002, "R4");
        expect_at(1, O_ERR, 16'h0001, "R5");
        wr(4'd3, 16'h0001);
        chk_rd(4'd3, 16'h0000, "R3");
        expect_at(1, O_OVF, 16'h0000, "R4");
        expect_at(1, O_ERR, 16'h0000, "R5");

        // R3: set wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 16'h0001; ovf_evt[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ovf_evt = '0;
        chk_rd(4'd3, 16'h0001, "R3");
        wr(4'd3, 16'h0001);
        chk_rd(4'd3, 16'h0000, "R3");
        wr(4'd2, 16'h0000);

        // R4: overflow on channel 4 without enable, then enable
        pulse(0, 4);
        chk_rd(4'd9, 16'h0001, "R3");
        expect_at(1, O_OVF, 16'h0000, "R4");
        expect_at(1, O_ERR, 16'h0000, "R5");
        wr(4'd8, 16'h1000);
        expect_at(1, O_OVF, 16'h0010, "R4");
        expect_at(1, O_ERR, 16'h0001, "R5");
        wr(4'd9, 16'h0001);
        wr(4'd8, 16'h0000);
        expect_at(1, O_OVF, 16'h0000, "R4");

        // R5: underflow on channel 3
        pulse(1, 3);
        chk_rd(4'd7, 16'h0002, "R3");
        expect_at(1, O_ERR, 16'h0000, "R5");
        wr(4'd6, 16'h0002);
        expect_at(1, O_ERR, 16'h0001, "R5");
        wr(4'd7, 16'h0002);
        chk_rd(4'd7, 16'h0000, "R3");
        expect_at(1, O_ERR, 16'h0000, "R5");

        // R5/R3: trigger overrun on channel 5, selective clear
        wr(4'd10, 16'h0001);
        pulse(2, 5);
        chk_rd(4'd11, 16'h0004, "R3");
        expect_at(1, O_ERR, 16'h0001, "R5");
        pulse(1, 5);
        chk_rd(4'd11, 16'h0006, "R3");
        wr(4'd11, 16'h0004);
        chk_rd(4'd11, 16'h0002, "R3");
        expect_at(1, O_ERR, 16'h0000, "R5");
        wr(4'd11, 16'h0002);
        wr(4'd10, 16'h0000);

        // R6: drain disabled, select set
        wr(4'd0, 16'h8000);
        set_ne(0, 1'b1);
        chk_rd(4'd1, 16'h0008, "R7");
        expect_at(0, O_DMA, 16'h0000, "R6");
        expect_at(0, O_DIRQ, 16'h0000, "R6");
        expect_at(2, O_DMA, 16'h0000, "R6");
        expect_at(2, O_DIRQ, 16'h0000, "R6");

        // R7: interrupt routing
        wr(4'd0, 16'h4000);
        expect_at(1, O_DIRQ, 16'h0001, "R7");
        expect_at(1, O_DMA, 16'h0000, "R7");
        set_ne(0, 1'b0);
        expect_at(0, O_DIRQ, 16'h0000, "R7");
        chk_rd(4'd1, 16'h0000, "R7");
        set_ne(0, 1'b1);
        expect_at(0, O_DIRQ, 16'h0001, "R7");

        // R8: DMA routing and hold
        wr(4'd0, 16'hC000);
        expect_at(1, O_DMA, 16'h0001, "R8");
        expect_at(1, O_DIRQ, 16'h0000, "R8");
        @(negedge clk);
        ack_pulse(0, 1'b1);
        expect_at(0, O_DMA, 16'h0001, "R8");
        set_ne(0, 1'b0);
        expect_at(0, O_DMA, 16'h0001, "R8");
        ack_pulse(0, 1'b0);
        expect_at(0, O_DMA, 16'h0000, "R8");
        expect_at(2, O_DMA, 16'h0000, "R8");
        repeat (2) @(negedge clk);

        // R9: protocol error on clearing select while outstanding
        set_ne(0, 1'b1);
        expect_at(0, O_DMA, 16'h0001, "R8");
        wr(4'd0, 16'h4000);
        expect_at(0, O_PERR, 16'h0001, "R9");
        expect_at(1, O_PERR, 16'h0000, "R9");
        expect_at(1, O_DMA, 16'h0000, "R9");
        wr(4'd0, 16'hC000);
        expect_at(0, O_PERR, 16'h0000, "R9");
        expect_at(1, O_DMA, 16'h0001, "R8");
        @(negedge clk);
        wr(4'd0, 16'hC000);
        expect_at(0, O_PERR, 16'h0000, "R9");
        wr(4'd2, 16'h0000);
        expect_at(0, O_PERR, 16'h0000, "R9");
        wr(4'd0, 16'h8000);
        expect_at(0, O_PERR, 16'h0001, "R9");
        expect_at(1, O_DMA, 16'h0000, "R6");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule